// File: doc/BRIEF.md
# Per-Channel Configuration Scan Chain

This block holds the programmable settings of a sixteen-channel signal-processing array and lets a slow programming clock, separate from the sampling clock, walk a single selection token across the channels. While the token sits on a channel, that channel's settings may be rewritten and its internal debug signals are routed out through a one-hot visibility select. During normal operation the token rests on no channel. In that state, no channel word can change and no visibility line is driven.

A programmer moves the token in two ways. It can park it with an idle request, or it can advance it one position per step strobe. The new settings are sent serially, least significant bit first, into an 18-bit staging register. A load strobe then copies the staging register into the selected channel. Each channel word is made of five fixed fields. Two of them set the lower and upper filter corners, two set the release and attack times, and one sets the converter reference. The same load strobe, issued while the token is parked, writes three global bits instead. These bits choose the per-channel sampling rate.

Top module: `cfgscan_chain`

## Requirements
- R1: After reset the token is parked (`vis_sel` is all zero), every channel word is zero and `rate_bits` is zero.
- R2: The token has two states, PARKED and ON_CHAN. A step strobe in PARKED moves it to ON_CHAN at channel 0. A step in ON_CHAN moves it to the next channel, and a step from channel 15 returns it to PARKED. `vis_sel` is one-hot on the selected channel in ON_CHAN and zero in PARKED.
- R3: An idle request takes the token to PARKED on the next edge from any state, and it wins over a step strobe in the same cycle.
- R4: With `prog_en` high, each `ser_shift` cycle moves `ser_in` into the top of the staging register and shifts the register one place toward bit 0. After 18 shifts, the first bit sent sits in bit 0. With `prog_en` high and the token ON_CHAN, `load` writes the staging register into the selected channel's word, and only that word changes.
- R5: With `prog_en` low, `load` and `ser_shift` have no effect: no channel word, no global bit and no staging content changes.
- R6: With `prog_en` high and the token PARKED, `load` copies staging bits [2:0] into `rate_bits` and leaves every channel word unchanged. A load while ON_CHAN leaves `rate_bits` unchanged.
- R7: `rate_choice` is one-hot and follows `rate_bits`. Codes 0, 1, 2 and 3 select 500 Hz, 1 kHz, 1.5 kHz and 2 kHz on bits 0, 1, 2 and 3. Codes 4 to 7 select the external rate on bit 4.
- R8: Channel k's word occupies `cfg_words[18k+17:18k]`. Within the word, the low filter corner is bits [4:0], the high filter corner [9:5], the release [12:10], the attack [14:13] and the converter reference [17:15].
- R9: When `load` and `ser_shift` are both high in one cycle, the word committed is the staging content from before that cycle's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Programming clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_en | input | 1 | Enables shifting and loading |
| tok_step | input | 1 | Advances the token one position |
| idle_req | input | 1 | Parks the token on no channel |
| ser_in | input | 1 | Serial configuration bit |
| ser_shift | input | 1 | Shifts `ser_in` into the staging register |
| load | input | 1 | Commits staging to the selected channel, or to the global bits when parked |
| cfg_words | output | 288 | Sixteen stored 18-bit channel words, channel 0 in the low bits |
| rate_bits | output | 3 | Stored global sampling-rate code |
| rate_choice | output | 5 | One-hot decoded sampling-rate choice |
| vis_sel | output | 16 | One-hot debug visibility select, zero when parked |

## Verification
The hardest situations to reach from the ports are a load that coincides with a shift, and the wrap from channel 15 back to PARKED. Reaching the wrap takes seventeen consecutive steps. The coinciding load and shift requires the staging register to hold a complete known word before the collision. The bench first parks the token, then steps to the target channel and sends a full word. Only after that does it raise shift and load together, so the outcome shows whether the old or the new staging value was committed. Writes to the global bits are also tested, using codes above 4. For these writes the token must be parked, and every channel word must be checked afterwards to show that none of them changed.

// File: rtl/cfgscan_pkg.sv
package cfgscan_pkg;

    localparam int LO_W  = 5;
    localparam int HI_W  = 5;
    localparam int REL_W = 3;
    localparam int ATK_W = 2;
    localparam int REF_W = 3;
    localparam int CFG_W = LO_W + HI_W + REL_W + ATK_W + REF_W;
    localparam int RATE_CODE_W = 3;
    localparam int RATE_OPT_N  = 5;

    // Field order from MSB to LSB; lo_corner lands in bits [4:0].
    typedef struct packed {
        logic [REF_W-1:0] conv_ref;
        logic [ATK_W-1:0] attack;
        logic [REL_W-1:0] release_t;
        logic [HI_W-1:0]  hi_corner;
        logic [LO_W-1:0]  lo_corner;
    } chan_cfg_t;

    typedef enum logic {
        TOK_PARKED  = 1'b0,
        TOK_ON_CHAN = 1'b1
    } tok_state_t;

    typedef enum logic [RATE_OPT_N-1:0] {
        RATE_500  = 5'b00001,
        RATE_1K   = 5'b00010,
        RATE_1K5  = 5'b00100,
        RATE_2K   = 5'b01000,
        RATE_EXT  = 5'b10000
    } rate_t;

    function automatic rate_t decode_rate(input logic [RATE_CODE_W-1:0] code);
        rate_t r;
        case (code)
            3'd0:    r = RATE_500;
            3'd1:    r = RATE_1K;
            3'd2:    r = RATE_1K5;
            3'd3:    r = RATE_2K;
            default: r = RATE_EXT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfgscan_token.sv
module cfgscan_token
    import cfgscan_pkg::*;
#(
    parameter int N_CHAN = 16,
    localparam int IDX_W = $clog2(N_CHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              park,
    output logic              sel_valid,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [N_CHAN-1:0] sel_onehot
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CHAN - 1);

    tok_state_t       state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TOK_PARKED;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

    // Transitions: park wins over step
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        if (park) begin
            state_n = TOK_PARKED;
            idx_n   = '0;
        end else if (step) begin
            unique case (state_q)
                TOK_PARKED: begin
                    state_n = TOK_ON_CHAN;
                    idx_n   = '0;
                end
                TOK_ON_CHAN: begin
                    if (idx_q == LAST_IDX) begin
                        state_n = TOK_PARKED;
                        idx_n   = '0;
                    end else begin
                        idx_n = idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        sel_valid  = 1'b0;
        sel_onehot = '0;
        unique case (state_q)
            TOK_PARKED:  sel_valid = 1'b0;
            TOK_ON_CHAN: begin
                sel_valid           = 1'b1;
                sel_onehot[idx_q]   = 1'b1;
            end
        endcase
    end

    assign sel_idx = idx_q;

endmodule

// File: rtl/cfgscan_stage.sv
module cfgscan_stage #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] stage
);

    // LSB-first: new bit enters at the top, earlier bits move down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (shift_en) begin
            stage <= {bit_in, stage[WORD_W-1:1]};
        end
    end

endmodule

// File: rtl/cfgscan_bank.sv
module cfgscan_bank
    import cfgscan_pkg::*;
#(
    parameter int N_CHAN = 16,
    parameter int WORD_W = CFG_W,
    localparam int IDX_W = $clog2(N_CHAN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    output logic [N_CHAN*WORD_W-1:0] words
);

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        chan_cfg_t cfg_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                cfg_q <= chan_cfg_t'(wr_data);
            end
        end
        assign words[g*WORD_W +: WORD_W] = WORD_W'(cfg_q);
    end

endmodule

// File: rtl/cfgscan_chain.sv
module cfgscan_chain
    import cfgscan_pkg::*;
#(
    parameter int N_CHAN = 16,
    parameter int WORD_W = CFG_W,
    localparam int IDX_W = $clog2(N_CHAN)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         prog_en,
    input  logic                         tok_step,
    input  logic                         idle_req,
    input  logic                         ser_in,
    input  logic                         ser_shift,
    input  logic                         load,
    output logic [N_CHAN*WORD_W-1:0]     cfg_words,
    output logic [RATE_CODE_W-1:0]       rate_bits,
    output logic [RATE_OPT_N-1:0]        rate_choice,
    output logic [N_CHAN-1:0]            vis_sel
);

    logic              sel_valid;
    logic [IDX_W-1:0]  sel_idx;
    logic [WORD_W-1:0] stage;
    logic              commit;
    logic [RATE_CODE_W-1:0] rate_q;

    assign commit = prog_en && load;

    cfgscan_token #(.N_CHAN(N_CHAN)) u_token (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (tok_step),
        .park       (idle_req),
        .sel_valid  (sel_valid),
        .sel_idx    (sel_idx),
        .sel_onehot (vis_sel)
    );

    cfgscan_stage #(.WORD_W(WORD_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (prog_en && ser_shift),
        .bit_in   (ser_in),
        .stage    (stage)
    );

    cfgscan_bank #(.N_CHAN(N_CHAN), .WORD_W(WORD_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit && sel_valid),
        .wr_idx  (sel_idx),
        .wr_data (stage),
        .words   (cfg_words)
    );

    // Global rate code is written only while the token is parked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
        end else if (commit && !sel_valid) begin
            rate_q <= stage[RATE_CODE_W-1:0];
        end
    end

    assign rate_bits   = rate_q;
    assign rate_choice = decode_rate(rate_q);

endmodule

// File: rtl/cfgscan_chain_chk.sv
module cfgscan_chain_chk
    import cfgscan_pkg::*;
#(
    parameter int N_CHAN = 16,
    parameter int WORD_W = CFG_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     prog_en,
    input logic                     tok_step,
    input logic                     idle_req,
    input logic                     load,
    input logic [N_CHAN*WORD_W-1:0] cfg_words,
    input logic [RATE_CODE_W-1:0]   rate_bits,
    input logic [RATE_OPT_N-1:0]    rate_choice,
    input logic [N_CHAN-1:0]        vis_sel
);

    p_vis_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vis_sel));

    p_step_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_req && tok_step && vis_sel == '0) |=> vis_sel[0]);

    p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_req && tok_step && vis_sel[N_CHAN-1]) |=> (vis_sel == '0));

    p_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |=> (vis_sel == '0));

    p_noen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> ($stable(cfg_words) && $stable(rate_bits)));

    p_idle_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && load && vis_sel == '0) |=> $stable(cfg_words));

    p_chan_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vis_sel != '0) |=> $stable(rate_bits));

    p_rate_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rate_choice));

endmodule

bind cfgscan_chain cfgscan_chain_chk #(.N_CHAN(N_CHAN), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_en     (prog_en),
    .tok_step    (tok_step),
    .idle_req    (idle_req),
    .load        (load),
    .cfg_words   (cfg_words),
    .rate_bits   (rate_bits),
    .rate_choice (rate_choice),
    .vis_sel     (vis_sel)
);

// File: tb/cfgscan_chain_bench.sv
module cfgscan_chain_bench;

    localparam int NCH = 16;
    localparam int WW  = 18;
    localparam int NVEC = 6;
    // {channel[3:0], word[17:0]}
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd0,  18'h2A5C3},
        {4'd15, 18'h3FFFF},
        {4'd9,  18'h00001},
        {4'd0,  18'h15A5A},
        {4'd4,  18'h20000},
        {4'd15, 18'h0F0F0}
    };

    logic clk = 1'b0;
    logic rst_n, prog_en, tok_step, idle_req, ser_in, ser_shift, load;
    logic [NCH*WW-1:0] cfg_words;
    logic [2:0]        rate_bits;
    logic [4:0]        rate_choice;
    logic [NCH-1:0]    vis_sel;

    int checks = 0;
    int fails  = 0;
    logic [WW-1:0] model [NCH];

    always #5 clk = ~clk;

    cfgscan_chain u_cfgscan_chain (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .tok_step(tok_step),
        .idle_req(idle_req), .ser_in(ser_in), .ser_shift(ser_shift), .load(load),
        .cfg_words(cfg_words), .rate_bits(rate_bits), .rate_choice(rate_choice),
        .vis_sel(vis_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        logic [NCH*WW-1:0] e;
        for (int c = 0; c < NCH; c++) e[c*WW +: WW] = model[c];
        checks++;
        if (cfg_words !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, cfg_words, e);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic park();
        idle_req = 1'b1; cyc(); idle_req = 1'b0;
    endtask

    task automatic go(input int ch);
        park();
        tok_step = 1'b1;
        repeat (ch + 1) cyc();
        tok_step = 1'b0;
    endtask

    task automatic send(input logic [WW-1:0] w, input logic en);
        prog_en = en; ser_shift = 1'b1;
        for (int i = 0; i < WW; i++) begin
            ser_in = w[i];
            cyc();
        end
        ser_shift = 1'b0; prog_en = 1'b0;
    endtask

    task automatic commit(input logic en);
        prog_en = en; load = 1'b1; cyc(); load = 1'b0; prog_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [WW-1:0] w;
        rst_n = 1'b0; prog_en = 0; tok_step = 0; idle_req = 0;
        ser_in = 0; ser_shift = 0; load = 0;
        for (int c = 0; c < NCH; c++) model[c] = '0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk_all("R1 words");
        chk("R1 vis_sel", 32'(vis_sel), 32'h0);
        chk("R1 rate_bits", 32'(rate_bits), 32'h0);
        chk("R7 reset choice", 32'(rate_choice), 32'h1);

        // Vector table: R4 write to selected channel only, R2 select
        for (int v = 0; v < NVEC; v++) begin
            go(int'(VEC[v][21:18]));
            chk("R2 vis_sel on channel", 32'(vis_sel), 32'(1) << VEC[v][21:18]);
            send(VEC[v][17:0], 1'b1);
            commit(1'b1);
            model[VEC[v][21:18]] = VEC[v][17:0];
            chk_all("R4 channel load");
        end

        // R2 stepping and wrap
        park();
        chk("R2 parked", 32'(vis_sel), 32'h0);
        tok_step = 1'b1; cyc();
        chk("R2 enter ch0", 32'(vis_sel), 32'h1);
        repeat (15) cyc();
        chk("R2 at ch15", 32'(vis_sel), 32'h8000);
        cyc();
        tok_step = 1'b0;
        chk("R2 wrap to parked", 32'(vis_sel), 32'h0);

        // R3 idle request beats step
        go(3);
        idle_req = 1'b1; tok_step = 1'b1; cyc();
        idle_req = 1'b0; tok_step = 1'b0;
        chk("R3 park priority", 32'(vis_sel), 32'h0);

        // R5 load and shift ignored without prog_en
        go(5);
        send(18'h1B3C7, 1'b1);
        commit(1'b0);
        chk_all("R5 load ignored");
        send(18'h0AAAA, 1'b0);
        commit(1'b1);
        model[5] = 18'h1B3C7;
        chk_all("R5 shift ignored");

        // R8 field positions
        w = {3'd6, 2'd2, 3'd5, 5'h0A, 5'h13};
        go(2);
        send(w, 1'b1);
        commit(1'b1);
        model[2] = w;
        chk_all("R8 word");
        chk("R8 attack field", 32'(cfg_words[2*WW+13 +: 2]), 32'd2);
        chk("R8 high corner field", 32'(cfg_words[2*WW+5 +: 5]), 32'h0A);

        // R9 simultaneous load and shift commits pre-shift value
        go(7);
        send(18'h2C1E5, 1'b1);
        prog_en = 1'b1; ser_shift = 1'b1; ser_in = 1'b1; load = 1'b1;
        cyc();
        prog_en = 1'b0; ser_shift = 1'b0; load = 1'b0;
        model[7] = 18'h2C1E5;
        chk_all("R9 pre-shift commit");
        chk("R6 rate unchanged by channel load", 32'(rate_bits), 32'h0);

        // R6 / R7 global rate code while parked
        for (int c = 0; c < 8; c++) begin
            park();
            send(18'h3FFF8 | 18'(c), 1'b1);
            commit(1'b1);
            chk("R6 rate_bits", 32'(rate_bits), 32'(c));
            chk("R7 rate_choice", 32'(rate_choice), (c <= 3) ? (32'(1) << c) : 32'h10);
        end
        chk_all("R6 words untouched by parked load");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule